// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This combinational block decides which input a three-operand fused multiply-add `(a*b)+c` should return when at least one operand is a NaN. A neighbouring unit classifies each operand and reports whether the product is infinity times zero. This block uses those inputs to return a 2-bit choice and a request to raise the invalid flag. That neighbouring unit also quiets the chosen operand and assembles the result word.

Several priority orderings are built in. A mode input selects one of them on every evaluation. Each ordering has its own rule for the infinity-times-zero product. Some orderings force the default NaN in that case; others return the addend. The block has no state. Both outputs follow the inputs within the same cycle.

Top module: `fma_nan_select`

## Requirements
- R1: Each operand class input is 2 bits: 00 = ordinary number, 01 = quiet NaN, 10 = signaling NaN, 11 = treated exactly as 00. The `pick` output means 0 = operand a, 1 = operand b, 2 = operand c, 3 = default NaN.
- R2: In mode 0 (addend-signaling-first), when `inf_zero` is high and c is a quiet NaN, `invalid` is 1 and `pick` is 3.
- R3: Otherwise in mode 0, the first match in this list wins: signaling c (2), signaling a (0), signaling b (1), quiet c (2), quiet a (0). If nothing matches, `pick` is 1.
- R4: In mode 1 (legacy), when `inf_zero` is high, `invalid` is 1 and `pick` is 3, whatever the classes are.
- R5: Otherwise in mode 1, the first match wins: signaling a, signaling b, signaling c, quiet a, quiet b. If nothing matches, `pick` is 2.
- R6: In mode 2 (2008 ordering), when `inf_zero` is high, `invalid` is 1 and `pick` is 2.
- R7: Otherwise in mode 2, the order is the same as in R3, with fallback 1.
- R8: In mode 3 (product-first), when `inf_zero` is high, `invalid` is 1 and `pick` is 2.
- R9: Otherwise in mode 3, `pick` is 0 if a is any NaN, else 2 if c is any NaN, else 1.
- R10: In modes 4 to 7 (plain), `pick` is 0 if a is any NaN, else 1 if b is any NaN, else 2. `inf_zero` has no effect in these modes.
- R11: `invalid` is 1 only on the infinity-times-zero paths of R2, R4, R6 and R8. A signaling operand alone never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 3 | Priority ordering select (R2 to R10) |
| cls_a | input | 2 | Class of multiplicand a |
| cls_b | input | 2 | Class of multiplier b |
| cls_c | input | 2 | Class of addend c |
| inf_zero | input | 1 | Product is infinity times zero |
| pick | output | 2 | Chosen source: a, b, c or default NaN |
| invalid | output | 1 | Request to raise the invalid flag |

## Verification
The hardest situation to reach is a combination where two rules compete. One case is `inf_zero` high while the addend is signaling rather than quiet in mode 0; there the override must not fire and the signaling rule must win. The other is the reserved class code 11 sitting next to real NaNs. The bench reaches every such corner by sweeping all 1024 combinations of mode, the three class codes and `inf_zero`. It compares each result against a model written from the requirement text.

// File: rtl/fnsel_pkg.sv
// Package: shared encodings for the FMA NaN selector.
// Assumes: class and mode codes are fixed by the requirements.
package fnsel_pkg;

    typedef enum logic [1:0] {
        CLS_NUM   = 2'b00,
        CLS_QUIET = 2'b01,
        CLS_SIG   = 2'b10,
        CLS_RSVD  = 2'b11
    } opnd_cls_e;

    typedef enum logic [2:0] {
        MODE_ADDEND_FIRST  = 3'd0,
        MODE_LEGACY        = 3'd1,
        MODE_STD2008       = 3'd2,
        MODE_PRODUCT_FIRST = 3'd3,
        MODE_PLAIN         = 3'd4
    } order_mode_e;

    localparam logic [1:0] PICK_A   = 2'd0;
    localparam logic [1:0] PICK_B   = 2'd1;
    localparam logic [1:0] PICK_C   = 2'd2;
    localparam logic [1:0] PICK_DFL = 2'd3;

endpackage

// File: rtl/fnsel_decode.sv
// Module: fnsel_decode
// Turns one operand class code into quiet / signaling / any-NaN flags.
// Assumes: the reserved code is handled as an ordinary number.
module fnsel_decode
    import fnsel_pkg::*;
(
    input  logic [1:0] cls,
    output logic       is_quiet,
    output logic       is_sig,
    output logic       is_nan
);

    // Decode the class code into one-hot NaN flags.
    always_comb begin
        is_quiet = 1'b0;
        is_sig   = 1'b0;
        unique case (opnd_cls_e'(cls))
            CLS_QUIET: is_quiet = 1'b1;
            CLS_SIG:   is_sig   = 1'b1;
            default:   ;
        endcase
        is_nan = is_quiet | is_sig;
    end

endmodule

// File: rtl/fnsel_pick.sv
// Module: fnsel_pick
// Generic first-hit priority picker: entry 0 has the highest priority.
// Assumes: codes[i] belongs to hit[i]; fallback applies when nothing hits.
module fnsel_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0]      hit,
    input  logic [N-1:0][1:0] codes,
    input  logic [1:0]        fallback,
    output logic [1:0]        sel
);

    // Scan from lowest to highest priority so the top entry wins.
    always_comb begin
        sel = fallback;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) sel = codes[i];
        end
    end

endmodule

// File: rtl/fma_nan_select.sv
// Module: fma_nan_select
// Chooses which operand (or the default NaN) a fused multiply-add returns
// when NaNs are present, and requests invalid on infinity-times-zero paths.
// Assumes: class codes and inf_zero come from an upstream classifier; the
// caller raises invalid for signaling operands itself.
module fma_nan_select
    import fnsel_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] cls_c,
    input  logic       inf_zero,
    output logic [1:0] pick,
    output logic       invalid
);

    localparam int NOPND = 3;   // operand index: 0 = a, 1 = b, 2 = c
    localparam int NSIG  = 5;   // entries in the signaling-aware orders
    localparam int NANY  = 2;   // entries in the any-NaN orders

    logic [NOPND-1:0] quiet, sig, anynan;
    logic [NOPND-1:0][1:0] cls_vec;

    assign cls_vec = {cls_c, cls_b, cls_a};

    genvar g;
    generate
        for (g = 0; g < NOPND; g++) begin : g_dec
            fnsel_decode u_dec (
                .cls      (cls_vec[g]),
                .is_quiet (quiet[g]),
                .is_sig   (sig[g]),
                .is_nan   (anynan[g])
            );
        end
    endgenerate

    // Order shared by modes 0 and 2: sig c, sig a, sig b, quiet c, quiet a.
    logic [1:0] sel_addend;
    fnsel_pick #(.N(NSIG)) u_addend (
        .hit      ({quiet[0], quiet[2], sig[1], sig[0], sig[2]}),
        .codes    ({PICK_A, PICK_C, PICK_B, PICK_A, PICK_C}),
        .fallback (PICK_B),
        .sel      (sel_addend)
    );

    // Legacy order: sig a, sig b, sig c, quiet a, quiet b.
    logic [1:0] sel_legacy;
    fnsel_pick #(.N(NSIG)) u_legacy (
        .hit      ({quiet[1], quiet[0], sig[2], sig[1], sig[0]}),
        .codes    ({PICK_B, PICK_A, PICK_C, PICK_B, PICK_A}),
        .fallback (PICK_C),
        .sel      (sel_legacy)
    );

    // Product-first order: any-NaN a, then any-NaN c.
    logic [1:0] sel_prod;
    fnsel_pick #(.N(NANY)) u_prod (
        .hit      ({anynan[2], anynan[0]}),
        .codes    ({PICK_C, PICK_A}),
        .fallback (PICK_B),
        .sel      (sel_prod)
    );

    // Plain order: any-NaN a, then any-NaN b.
    logic [1:0] sel_plain;
    fnsel_pick #(.N(NANY)) u_plain (
        .hit      ({anynan[1], anynan[0]}),
        .codes    ({PICK_B, PICK_A}),
        .fallback (PICK_C),
        .sel      (sel_plain)
    );

    // Apply the per-mode infinity-times-zero override, then the ordering.
    always_comb begin
        invalid = 1'b0;
        pick    = sel_plain;
        case (mode)
            MODE_ADDEND_FIRST: begin
                if (inf_zero && quiet[2]) begin
                    invalid = 1'b1;
                    pick    = PICK_DFL;
                end else begin
                    pick = sel_addend;
                end
            end
            MODE_LEGACY: begin
                invalid = inf_zero;
                pick    = inf_zero ? PICK_DFL : sel_legacy;
            end
            MODE_STD2008: begin
                invalid = inf_zero;
                pick    = inf_zero ? PICK_C : sel_addend;
            end
            MODE_PRODUCT_FIRST: begin
                invalid = inf_zero;
                pick    = inf_zero ? PICK_C : sel_prod;
            end
            default: begin
                invalid = 1'b0;
                pick    = sel_plain;
            end
        endcase
    end

endmodule

// File: rtl/fma_nan_select_chk.sv
// Module: fma_nan_select_chk
// Port-level checks on the selector, attached by bind.
// Assumes: inputs settle before each evaluation of the checks.
module fma_nan_select_chk (
    input logic [2:0] mode,
    input logic [1:0] cls_a,
    input logic [1:0] cls_b,
    input logic [1:0] cls_c,
    input logic       inf_zero,
    input logic [1:0] pick,
    input logic       invalid
);

    // Evaluate the immediate checks whenever any port changes.
    always_comb begin
        // R11: invalid only ever accompanies an infinity-times-zero product
        assert_inv_needs_iz_R11: assert (!invalid || inf_zero);
        // R10: plain modes never raise invalid
        assert_plain_no_inv_R10: assert (!(mode[2] && invalid));
        // R1: operand a is chosen only when it is a NaN
        assert_a_is_nan_R1: assert (pick != 2'd0 || cls_a == 2'b01 || cls_a == 2'b10);
        // R2: the default NaN is chosen only with an invalid request
        assert_dfl_with_inv_R2: assert (pick != 2'd3 || invalid);
        // R6: in the 2008 and product-first modes invalid returns the addend
        assert_iz_addend_R6: assert (!((mode == 3'd2 || mode == 3'd3) && invalid) || pick == 2'd2);
    end

endmodule

bind fma_nan_select fma_nan_select_chk u_chk (
    .mode     (mode),
    .cls_a    (cls_a),
    .cls_b    (cls_b),
    .cls_c    (cls_c),
    .inf_zero (inf_zero),
    .pick     (pick),
    .invalid  (invalid)
);

// File: tb/sim_fma_nan_select.sv
// Bench: exhaustive sweep of mode, three class codes and inf_zero,
// compared against a model written from the requirement text.
module sim_fma_nan_select;

    logic       clk = 1'b0;
    logic [2:0] mode;
    logic [1:0] cls_a, cls_b, cls_c;
    logic       inf_zero;
    logic [1:0] pick;
    logic       invalid;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    fma_nan_select u0 (
        .mode     (mode),
        .cls_a    (cls_a),
        .cls_b    (cls_b),
        .cls_c    (cls_c),
        .inf_zero (inf_zero),
        .pick     (pick),
        .invalid  (invalid)
    );

    // Reference from the requirements: returns {invalid, pick}.
    function automatic logic [2:0] model(input int m, input logic [1:0] ca,
                                         input logic [1:0] cb, input logic [1:0] cc,
                                         input logic iz);
        logic qa, qb, qc, sa, sb, sc, na, nb, nc;
        qa = (ca == 2'b01); qb = (cb == 2'b01); qc = (cc == 2'b01);
        sa = (ca == 2'b10); sb = (cb == 2'b10); sc = (cc == 2'b10);
        na = qa | sa; nb = qb | sb; nc = qc | sc;
        case (m)
            0: begin
                if (iz && qc) return 3'b1_11;
                if (sc) return 3'd2; if (sa) return 3'd0; if (sb) return 3'd1;
                if (qc) return 3'd2; if (qa) return 3'd0; return 3'd1;
            end
            1: begin
                if (iz) return 3'b1_11;
                if (sa) return 3'd0; if (sb) return 3'd1; if (sc) return 3'd2;
                if (qa) return 3'd0; if (qb) return 3'd1; return 3'd2;
            end
            2: begin
                if (iz) return 3'b1_10;
                if (sc) return 3'd2; if (sa) return 3'd0; if (sb) return 3'd1;
                if (qc) return 3'd2; if (qa) return 3'd0; return 3'd1;
            end
            3: begin
                if (iz) return 3'b1_10;
                if (na) return 3'd0; if (nc) return 3'd2; return 3'd1;
            end
            default: begin
                if (na) return 3'd0; if (nb) return 3'd1; return 3'd2;
            end
        endcase
    endfunction

    // Name the requirement a given combination exercises.
    function automatic string tag_of(input int m, input logic iz, input logic [1:0] cc,
                                     input bit rsvd);
        string t;
        case (m)
            0: t = (iz && cc == 2'b01) ? "R2" : "R3";
            1: t = iz ? "R4" : "R5";
            2: t = iz ? "R6" : "R7";
            3: t = iz ? "R8" : "R9";
            default: t = "R10";
        endcase
        if (rsvd) t = {"R1 ", t};
        return t;
    endfunction

    initial begin
        mode = '0; cls_a = '0; cls_b = '0; cls_c = '0; inf_zero = 1'b0;
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        for (int z = 0; z < 2; z++) begin
                            logic [2:0] exp;
                            string      tg;
                            @(posedge clk);
                            mode = 3'(m); cls_a = 2'(a); cls_b = 2'(b); cls_c = 2'(c);
                            inf_zero = 1'(z);
                            @(negedge clk);
                            exp = model(m, 2'(a), 2'(b), 2'(c), 1'(z));
                            tg  = tag_of(m, 1'(z), 2'(c), (a == 3 || b == 3 || c == 3));
                            checks++;
                            if (pick !== exp[1:0]) begin
                                errors++;
                                $display("FAIL %s pick mode=%0d cls=%0d/%0d/%0d iz=%0d: got %0d expected %0d",
                                         tg, m, a, b, c, z, pick, exp[1:0]);
                            end
                            checks++;
                            if (invalid !== exp[2]) begin
                                errors++;
                                $display("FAIL R11 (%s) invalid mode=%0d cls=%0d/%0d/%0d iz=%0d: got %0b expected %0b",
                                         tg, m, a, b, c, z, invalid, exp[2]);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule